// File: doc/BRIEF.md
# Pipelined Quasi-Cyclic Parity Syndrome Checker

This block decides whether a hard-decision word meets every parity check of a quasi-cyclic low-density parity-check code. The code is built from 7 block rows by 8 block columns of 32x32 circulants. That gives 256 coded bits and 224 checks. A decoder hands the block the sign bits of its 256 beliefs as one flat vector and a one-cycle start pulse. The block returns the number of unsatisfied checks, a flag that is high when that number is zero, and a one-cycle done pulse. The decoder's next state reads the flag to decide whether to stop iterating.

The work is split over two registered stages so that no path goes through both the parity logic and the counting logic. The first stage forms all 224 parity bits in parallel, each from at most three sign bits, and registers them. The second stage reduces the registered parity vector with a balanced tree of four-input adders and registers the weight and the flag. The table of circulant shifts is a constant computed at elaboration. A new word can be accepted on every clock.

Top module: `synCheckTop`

## Requirements
- R1: Block row r (0..6) connects to block column c (0..7) exactly when c = r, c = r+1, or c = (r+4) mod 8, with shift s = (3r + 7c) mod 32. Check r*32+j is the XOR of sign bits c*32 + ((j+s) mod 32) over the connected columns c.
- R2: The reported weight equals the number of the 224 checks whose XOR is 1.
- R3: The ok flag is high exactly when the reported weight is zero.
- R4: When start is high at rising edge n, done is low after edge n. After edge n+1, done is high for one cycle and the weight and flag for that word are valid.
- R5: Starts on consecutive cycles are each accepted. Their results appear on consecutive cycles, in order.
- R6: Without start, changes on the sign vector have no effect. Done stays low, and the weight and flag hold their last values.
- R7: A synchronous active-high reset clears the weight to 0 and drives the flag and done low.
- R8: The weight never exceeds 224. A word with every sign bit set gives 224, because each row connects an odd number of columns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| startIn | input | 1 | Samples signIn on this edge |
| signIn | input | 256 | Belief sign bits; bit c*32+k is position k of block column c |
| weightOut | output | 8 | Count of unsatisfied checks |
| okOut | output | 1 | High when all checks are satisfied |
| doneOut | output | 1 | One-cycle pulse when weightOut and okOut are new |

## Verification
The hardest case to reach from the ports is a full pipeline: a result leaves stage 2 on the same edge that a new word enters stage 1. Only then is a mix-up between stage contents visible. The bench drives three different words on back-to-back cycles and checks each weight in order against its own word. The rotation rule is reached through vectors with a known answer: a single set bit hits one check per connected row, and a fully set block column fails every check of its rows. This exercises the column degree and the shift mapping without relying on the design.

// File: rtl/synChkPkg.sv
package synChkPkg;

  localparam int BLK_ROWS = 7;
  localparam int BLK_COLS = 8;
  localparam int LIFT     = 32;

  typedef struct packed {
    logic capture;  // register parity vector from signIn
    logic reduce;   // register tree sum into weight and flag
  } synStrobe_t;

  // Circulant shift of block (r,c), or -1 when the block is empty.
  function automatic int shiftOf(input int r, input int c, input int cols, input int lift);
    if (c == r || c == r + 1 || c == (r + 4) % cols)
      return (3 * r + 7 * c) % lift;
    return -1;
  endfunction

  // Number of four-input tree levels needed to cover n leaves.
  function automatic int levelsFor(input int n);
    int lv;
    int span;
    lv = 0;
    span = 1;
    while (span < n) begin
      span = span * 4;
      lv = lv + 1;
    end
    return lv;
  endfunction

endpackage

// File: rtl/synCtrl.sv
module synCtrl
  import synChkPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startIn,
  output synStrobe_t strobe,
  output logic       doneOut
);

  logic stage1Q;
  logic doneQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1Q <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      stage1Q <= startIn;
      doneQ   <= stage1Q;
    end
  end

  always_comb begin
    strobe.capture = startIn;
    strobe.reduce  = stage1Q;
  end

  assign doneOut = doneQ;

endmodule

// File: rtl/synDatapath.sv
module synDatapath
  import synChkPkg::*;
#(
  parameter int ROWS = BLK_ROWS,
  parameter int COLS = BLK_COLS,
  parameter int Z    = LIFT,
  localparam int NBITS    = COLS * Z,
  localparam int NCHECK   = ROWS * Z,
  localparam int WEIGHT_W = $clog2(NCHECK + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  synStrobe_t          strobe,
  input  logic [NBITS-1:0]    signIn,
  output logic [WEIGHT_W-1:0] weightOut,
  output logic                okOut
);

  localparam int LVLS   = levelsFor(NCHECK);
  localparam int LEAVES = 4 ** LVLS;

  // Stage 1: every check is the XOR of at most three rotated sign bits.
  logic [NCHECK-1:0] parityD;
  logic [NCHECK-1:0] parityQ;

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      for (int j = 0; j < Z; j++) begin
        parityD[r*Z + j] = 1'b0;
        for (int c = 0; c < COLS; c++) begin
          if (shiftOf(r, c, COLS, Z) >= 0)
            parityD[r*Z + j] = parityD[r*Z + j]
                             ^ signIn[c*Z + ((j + shiftOf(r, c, COLS, Z)) % Z)];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 parityQ <= '0;
    else if (strobe.capture) parityQ <= parityD;
  end

  // Stage 2: balanced tree of four-input adders over the parity register.
  for (genvar lv = 0; lv <= LVLS; lv++) begin : lvlG
    localparam int CNT = LEAVES >> (2 * lv);
    logic [WEIGHT_W-1:0] sums [CNT];
    if (lv == 0) begin : leafG
      for (genvar i = 0; i < CNT; i++) begin : leafNodeG
        if (i < NCHECK) begin : usedG
          assign sums[i] = WEIGHT_W'(parityQ[i]);
        end else begin : padG
          assign sums[i] = '0;
        end
      end
    end else begin : nodeG
      for (genvar n = 0; n < CNT; n++) begin : addG
        assign sums[n] = lvlG[lv-1].sums[4*n]     + lvlG[lv-1].sums[4*n + 1]
                       + lvlG[lv-1].sums[4*n + 2] + lvlG[lv-1].sums[4*n + 3];
      end
    end
  end

  logic [WEIGHT_W-1:0] treeSum;
  logic [WEIGHT_W-1:0] weightQ;
  logic                okQ;

  assign treeSum = lvlG[LVLS].sums[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      weightQ <= '0;
      okQ     <= 1'b0;
    end else if (strobe.reduce) begin
      weightQ <= treeSum;
      okQ     <= (treeSum == '0);
    end
  end

  assign weightOut = weightQ;
  assign okOut     = okQ;

endmodule

// File: rtl/synCheckTop.sv
module synCheckTop
  import synChkPkg::*;
#(
  parameter int ROWS = BLK_ROWS,
  parameter int COLS = BLK_COLS,
  parameter int Z    = LIFT
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              startIn,
  input  logic [COLS*Z-1:0]                 signIn,
  output logic [$clog2(ROWS*Z+1)-1:0]       weightOut,
  output logic                              okOut,
  output logic                              doneOut
);

  synStrobe_t strobe;

  synCtrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .startIn (startIn),
    .strobe  (strobe),
    .doneOut (doneOut)
  );

  synDatapath #(
    .ROWS (ROWS),
    .COLS (COLS),
    .Z    (Z)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .signIn    (signIn),
    .weightOut (weightOut),
    .okOut     (okOut)
  );

endmodule

// File: rtl/synCheckAssert.sv
module synCheckAssert #(
  parameter int ROWS = 7,
  parameter int Z    = 32,
  localparam int NCHECK   = ROWS * Z,
  localparam int WEIGHT_W = $clog2(NCHECK + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                startIn,
  input logic [WEIGHT_W-1:0] weightOut,
  input logic                okOut,
  input logic                doneOut
);

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst) startIn |=> ##1 doneOut); // R4
  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (rst) doneOut |-> $past(startIn, 2)); // R5
  AST_OK_IFF_ZERO: assert property (@(posedge clk) disable iff (rst) doneOut |-> (okOut == (weightOut == '0))); // R3
  AST_HOLD_WITHOUT_DONE: assert property (@(posedge clk) disable iff (rst) (!doneOut && !$past(rst)) |-> ($stable(weightOut) && $stable(okOut))); // R6
  AST_WEIGHT_RANGE: assert property (@(posedge clk) disable iff (rst) weightOut <= WEIGHT_W'(NCHECK)); // R8

endmodule

bind synCheckTop synCheckAssert #(.ROWS(ROWS), .Z(Z)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .startIn   (startIn),
  .weightOut (weightOut),
  .okOut     (okOut),
  .doneOut   (doneOut)
);

// File: tb/synCheckTop_tb_top.sv
module synCheckTop_tb_top;

  localparam int NB = 256;
  localparam int NTAB = 8;

  // Stimulus words and the weights the rule in R1 gives for them.
  localparam logic [NB-1:0] STIM [NTAB] = '{
    {NB{1'b0}},
    {NB{1'b1}},
    NB'(1),
    NB'(1) << 163,
    NB'(1) << 255,
    (NB'(1) << 160) | (NB'(1) << 161),
    NB'(32'hFFFF_FFFF) << 160,
    NB'(32'hFFFF_FFFF)
  };
  localparam int EXPW [NTAB] = '{0, 224, 2, 3, 2, 6, 96, 64};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          startIn = 1'b0;
  logic [NB-1:0] signIn = '0;
  logic [7:0]    weightOut;
  logic          okOut;
  logic          doneOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  synCheckTop dut_i (
    .clk       (clk),
    .rst       (rst),
    .startIn   (startIn),
    .signIn    (signIn),
    .weightOut (weightOut),
    .okOut     (okOut),
    .doneOut   (doneOut)
  );

  function automatic int refWeight(input logic [NB-1:0] v);
    int w;
    w = 0;
    for (int r = 0; r < 7; r++) begin
      for (int j = 0; j < 32; j++) begin
        logic p;
        p = 1'b0;
        for (int c = 0; c < 8; c++) begin
          if (c == r || c == r + 1 || c == (r + 4) % 8)
            p = p ^ v[c*32 + ((j + (3*r + 7*c) % 32) % 32)];
        end
        w = w + int'(p);
      end
    end
    return w;
  endfunction

  task automatic check(input bit good, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!good) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  // Runs one word with full latency checks; all activity on falling edges.
  task automatic runOne(input logic [NB-1:0] v, input int expW, input string req);
    @(negedge clk);
    signIn  = v;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check(doneOut == 1'b0, "R4", "done early", int'(doneOut), 0);
    @(negedge clk);
    check(doneOut == 1'b1, "R4", "done on second edge", int'(doneOut), 1);
    check(int'(weightOut) == expW, req, "weight", int'(weightOut), expW);
    check(okOut == (expW == 0), "R3", "ok flag", int'(okOut), int'(expW == 0));
    @(negedge clk);
    check(doneOut == 1'b0, "R4", "done one cycle", int'(doneOut), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [NB-1:0] a;
    logic [NB-1:0] b;
    logic [NB-1:0] c;
    int wA;
    int wB;
    int wC;
    int held;

    repeat (3) @(negedge clk);
    // R7: reset state
    check(weightOut == 8'd0, "R7", "weight in reset", int'(weightOut), 0);
    check(okOut == 1'b0, "R7", "ok in reset", int'(okOut), 0);
    check(doneOut == 1'b0, "R7", "done in reset", int'(doneOut), 0);
    rst = 1'b0;

    // Table walk: R1 rotation and degree, R2 count, R8 all-ones maximum.
    for (int i = 0; i < NTAB; i++) begin
      check(refWeight(STIM[i]) == EXPW[i], "R1", "model vs table", refWeight(STIM[i]), EXPW[i]);
      runOne(STIM[i], EXPW[i], (i == 1) ? "R8" : "R2");
    end

    // R2: pseudo-random words against the model
    for (int k = 0; k < 20; k++) begin
      logic [NB-1:0] v;
      for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
      runOne(v, refWeight(v), "R2");
      check(weightOut <= 8'd224, "R8", "range", int'(weightOut), 224);
    end

    // R5: three starts back to back
    for (int w = 0; w < 8; w++) begin
      a[w*32 +: 32] = $urandom;
      b[w*32 +: 32] = $urandom;
      c[w*32 +: 32] = $urandom;
    end
    wA = refWeight(a);
    wB = refWeight(b);
    wC = refWeight(c);
    @(negedge clk); signIn = a; startIn = 1'b1;
    @(negedge clk); signIn = b;
    check(doneOut == 1'b0, "R5", "no result yet", int'(doneOut), 0);
    @(negedge clk); signIn = c;
    check(doneOut == 1'b1 && int'(weightOut) == wA, "R5", "first weight", int'(weightOut), wA);
    @(negedge clk); startIn = 1'b0;
    check(doneOut == 1'b1 && int'(weightOut) == wB, "R5", "second weight", int'(weightOut), wB);
    @(negedge clk);
    check(doneOut == 1'b1 && int'(weightOut) == wC, "R5", "third weight", int'(weightOut), wC);
    @(negedge clk);
    check(doneOut == 1'b0, "R5", "train ended", int'(doneOut), 0);

    // R6: sign changes without start are ignored
    runOne(NB'(1) << 163, 3, "R2");
    held = int'(weightOut);
    signIn = {NB{1'b1}};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      signIn = ~signIn;
      check(doneOut == 1'b0, "R6", "done without start", int'(doneOut), 0);
      check(int'(weightOut) == held && okOut == 1'b0, "R6", "weight held", int'(weightOut), held);
    end

    // R7: reset after a nonzero result
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(weightOut == 8'd0, "R7", "weight after reset", int'(weightOut), 0);
    check(okOut == 1'b0 && doneOut == 1'b0, "R7", "flags after reset",
          int'({okOut, doneOut}), 0);

    // R3: ok flag rises again for a clean word after a failing one
    runOne({NB{1'b0}}, 0, "R3");

    finishRun();
  end

endmodule